// File: doc/BRIEF.md
# Register-Driven SPI Command Engine

This block is a SPI host that software drives one byte at a time through a small register window. Software first loads three registers: a command opcode, a count of bytes to send, and a count of bytes to receive. It then writes the outgoing payload into a shared data buffer and sets the go bit. The engine lowers chip select and shifts out the opcode. It then sends the payload bytes, and after those it clocks in the requested number of reply bytes. Each reply byte is written into the same buffer, in the slots that follow the payload. A status word shows the busy flag, how many bytes after the opcode have completed, and the engine's two buffer pointers.

The serial side uses SPI mode 0 and sends MSB first. SCLK idles low, and each half-period of SCLK lasts `HALF_DIV` system clocks. The sequencer has five states. `ST_IDLE` goes to `ST_LEAD` when a valid go write arrives. `ST_LEAD` goes to `ST_HIGH` when its half-period ends. From `ST_HIGH`, the engine goes to `ST_LOW` when more bits or bytes remain, and to `ST_TRAIL` after bit 7 of the last byte. `ST_LOW` goes back to `ST_HIGH`. `ST_TRAIL` returns to `ST_IDLE`. Every state lasts one half-period, and the rising SCLK edge falls on each entry to `ST_HIGH`.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCLK is low, and all four status bytes (0x4C to 0x4F) read as zero.
- R2: Byte registers sit at fixed offsets and read back what was written while idle: opcode at 0x45, send count at 0x48, receive count at 0x4B. Offsets 0x80 to 0x80+DEPTH-1 address buffer slots 0 to DEPTH-1.
- R3: A write to 0x47 with bit 7 set, made while idle, starts a transaction at that clock edge. The same write with bit 7 clear has no effect.
- R4: The status word is little-endian at 0x4C. Bit 31 is busy. Bits 7:0 hold the done count. Bits 14:8 hold the write pointer, which counts reply bytes stored. Bits 22:16 hold the read pointer, which counts payload bytes fetched. A start clears all three counters.
- R5: MOSI carries the opcode first, then buffer slots 0 to tx-1, then 0xFF for each reply byte, MSB first. MOSI holds steady while SCLK is high.
- R6: Chip select falls at the start edge. SCLK first rises HALF_DIV cycles later, and every SCLK phase lasts HALF_DIV cycles. Busy and low chip select last exactly (16·N+1)·HALF_DIV cycles, with N = 1+tx+rx.
- R7: Reply byte i is stored in buffer slot tx+i at the edge that samples its eighth bit.
- R8: The done count rises by one at the end of each byte after the opcode. It ends at tx+rx.
- R9: With both counts zero, only the opcode is sent, and busy lasts 17·HALF_DIV cycles.
- R10: While busy, writes to the opcode, the counts, the go register and the buffer are ignored.
- R11: SCLK is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Byte write offset |
| wr_data | input | 8 | Byte write data |
| rd_addr | input | 8 | Byte read offset |
| rd_data | output | 8 | Byte read data (combinational) |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The checker confirms on every cycle the following: SCLK stays parked while chip select is high; MOSI holds through each high phase; the configuration stays frozen during a transaction; the done count moves by at most one per cycle and never passes tx+rx; both pointers stay inside their counts; and a start clears the counters. Other properties need a modelled SPI device and a known payload, so only the bench scenarios can show them. These are the exact byte order on MOSI, the placement of reply bytes at tx+i, the total transaction length, and the rejection of writes made mid-transfer.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TRAIL
    } seq_state_e;

    localparam logic [7:0] OFS_OPCODE = 8'h45;
    localparam logic [7:0] OFS_GO     = 8'h47;
    localparam logic [7:0] OFS_TXN    = 8'h48;
    localparam logic [7:0] OFS_RXN    = 8'h4B;
    localparam logic [7:0] OFS_STAT0  = 8'h4C;
    localparam logic [7:0] OFS_STAT1  = 8'h4D;
    localparam logic [7:0] OFS_STAT2  = 8'h4E;
    localparam logic [7:0] OFS_STAT3  = 8'h4F;
    localparam logic [7:0] OFS_WIN    = 8'h80;
    localparam int         GO_BIT     = 7;
    localparam logic [7:0] RX_FILL    = 8'hFF;
endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int DEPTH = 71,
    parameter int PTR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [7:0]       rd_addr,
    output logic [7:0]       rd_data,
    input  logic             busy,
    input  logic [7:0]       done,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic             eng_we,
    input  logic [PTR_W-1:0] eng_waddr,
    input  logic [7:0]       eng_wdata,
    input  logic [PTR_W-1:0] eng_raddr,
    output logic [7:0]       eng_rdata,
    output logic [7:0]       opcode,
    output logic [7:0]       tx_cnt,
    output logic [7:0]       rx_cnt,
    output logic             start
);
    logic [7:0]       fifo [DEPTH];
    logic [7:0]       wr_off, rd_off;
    logic             wr_hit, rd_hit, host_fifo_we, cfg_we;
    logic [PTR_W-1:0] wr_idx, rd_idx;

    assign wr_off       = wr_addr - OFS_WIN;
    assign rd_off       = rd_addr - OFS_WIN;
    assign wr_hit       = (wr_addr >= OFS_WIN) && (int'(wr_off) < DEPTH);
    assign rd_hit       = (rd_addr >= OFS_WIN) && (int'(rd_off) < DEPTH);
    assign wr_idx       = PTR_W'(wr_off);
    assign rd_idx       = PTR_W'(rd_off);
    assign cfg_we       = wr_en && !busy;
    assign host_fifo_we = cfg_we && wr_hit;
    assign start        = cfg_we && (wr_addr == OFS_GO) && wr_data[GO_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opcode <= '0;
            tx_cnt <= '0;
            rx_cnt <= '0;
        end else if (cfg_we) begin
            if (wr_addr == OFS_OPCODE) opcode <= wr_data;
            if (wr_addr == OFS_TXN)    tx_cnt <= wr_data;
            if (wr_addr == OFS_RXN)    rx_cnt <= wr_data;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                fifo[g] <= '0;
            else if (eng_we && eng_waddr == PTR_W'(g))
                fifo[g] <= eng_wdata;
            else if (host_fifo_we && wr_idx == PTR_W'(g))
                fifo[g] <= wr_data;
        end
    end

    assign eng_rdata = (int'(eng_raddr) < DEPTH) ? fifo[eng_raddr] : 8'h00;

    always_comb begin
        rd_data = '0;
        if (rd_hit) begin
            rd_data = fifo[rd_idx];
        end else begin
            case (rd_addr)
                OFS_OPCODE: rd_data = opcode;
                OFS_TXN:    rd_data = tx_cnt;
                OFS_RXN:    rd_data = rx_cnt;
                OFS_STAT0:  rd_data = done;
                OFS_STAT1:  rd_data = {1'b0, 7'(wr_ptr)};
                OFS_STAT2:  rd_data = {1'b0, 7'(rd_ptr)};
                OFS_STAT3:  rd_data = {busy, 7'b0};
                default:    rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_cmd_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int DEPTH    = 71,
    parameter int PTR_W    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       opcode,
    input  logic [7:0]       tx_cnt,
    input  logic [7:0]       rx_cnt,
    input  logic [7:0]       eng_rdata,
    output logic [PTR_W-1:0] eng_raddr,
    output logic             eng_we,
    output logic [PTR_W-1:0] eng_waddr,
    output logic [7:0]       eng_wdata,
    output logic             busy,
    output logic [7:0]       done,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    seq_state_e       state, state_nx;
    logic [CNT_W-1:0] half_cnt;
    logic [2:0]       bit_cnt;
    logic [7:0]       shreg;
    logic [6:0]       rxsh;
    logic             in_data, is_rx;
    logic             half_end, rise, fall, last_byte;
    logic [7:0]       next_done;
    logic [8:0]       total, rx_slot;

    assign half_end  = (half_cnt == CNT_W'(HALF_DIV - 1));
    assign total     = 9'(tx_cnt) + 9'(rx_cnt);
    assign next_done = in_data ? done + 8'd1 : 8'd0;
    assign last_byte = (9'(next_done) == total);
    assign rx_slot   = 9'(tx_cnt) + 9'(wr_ptr);
    assign rise      = (state == ST_LEAD || state == ST_LOW) && half_end;
    assign fall      = (state == ST_HIGH) && half_end;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)    state_nx = ST_LEAD;
            ST_LEAD:  if (half_end) state_nx = ST_HIGH;
            ST_HIGH:  if (half_end) state_nx = (bit_cnt == 3'd7 && last_byte) ? ST_TRAIL : ST_LOW;
            ST_LOW:   if (half_end) state_nx = ST_HIGH;
            ST_TRAIL: if (half_end) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_cnt <= '0;
            bit_cnt  <= '0;
            shreg    <= '0;
            rxsh     <= '0;
            in_data  <= 1'b0;
            is_rx    <= 1'b0;
            done     <= '0;
            wr_ptr   <= '0;
            rd_ptr   <= '0;
        end else begin
            if (state == ST_IDLE) half_cnt <= '0;
            else                  half_cnt <= half_end ? '0 : half_cnt + 1'b1;

            if (state == ST_IDLE && start) begin
                shreg   <= opcode;
                bit_cnt <= '0;
                in_data <= 1'b0;
                is_rx   <= 1'b0;
                done    <= '0;
                wr_ptr  <= '0;
                rd_ptr  <= '0;
            end

            if (rise) begin
                rxsh <= {rxsh[5:0], miso};
                if (is_rx && bit_cnt == 3'd7) wr_ptr <= wr_ptr + 1'b1;
            end

            if (fall) begin
                if (bit_cnt != 3'd7) begin
                    shreg   <= {shreg[6:0], 1'b0};
                    bit_cnt <= bit_cnt + 3'd1;
                end else begin
                    bit_cnt <= '0;
                    if (in_data) done <= done + 8'd1;
                    if (!last_byte) begin
                        in_data <= 1'b1;
                        if (next_done < tx_cnt) begin
                            shreg  <= eng_rdata;
                            rd_ptr <= rd_ptr + 1'b1;
                            is_rx  <= 1'b0;
                        end else begin
                            shreg <= RX_FILL;
                            is_rx <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        cs_n      = (state == ST_IDLE);
        sclk      = (state == ST_HIGH);
        mosi      = busy & shreg[7];
        eng_raddr = rd_ptr;
        eng_we    = rise && is_rx && (bit_cnt == 3'd7) && (rx_slot < 9'(DEPTH));
        eng_waddr = PTR_W'(rx_slot);
        eng_wdata = {rxsh, miso};
    end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int DEPTH    = 71
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       spi_sclk,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    localparam int PTR_W = $clog2(DEPTH + 1);

    logic             busy, start, eng_we;
    logic [7:0]       done, opcode, tx_cnt, rx_cnt, eng_wdata, eng_rdata;
    logic [PTR_W-1:0] wr_ptr, rd_ptr, eng_waddr, eng_raddr;

    spi_cmd_regs #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done(done), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .eng_we(eng_we), .eng_waddr(eng_waddr), .eng_wdata(eng_wdata),
        .eng_raddr(eng_raddr), .eng_rdata(eng_rdata),
        .opcode(opcode), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .start(start)
    );

    spi_cmd_seq #(.HALF_DIV(HALF_DIV), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .opcode(opcode), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
        .eng_rdata(eng_rdata), .eng_raddr(eng_raddr),
        .eng_we(eng_we), .eng_waddr(eng_waddr), .eng_wdata(eng_wdata),
        .busy(busy), .done(done), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
    );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
    parameter int PTR_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             sclk,
    input logic             mosi,
    input logic             busy,
    input logic [7:0]       done,
    input logic [PTR_W-1:0] rd_ptr,
    input logic [PTR_W-1:0] wr_ptr,
    input logic [7:0]       opcode,
    input logic [7:0]       tx_cnt,
    input logic [7:0]       rx_cnt
);
    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R11
    AST_CS_FALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> !sclk); // R6
    AST_MOSI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi)); // R5
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(opcode) && $stable(tx_cnt) && $stable(rx_cnt))); // R10
    AST_DONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (done == $past(done) || done == $past(done) + 8'd1)); // R8
    AST_DONE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (9'(done) <= 9'(tx_cnt) + 9'(rx_cnt))); // R8
    AST_RDPTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (8'(rd_ptr) <= tx_cnt)); // R4
    AST_WRPTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (8'(wr_ptr) <= rx_cnt)); // R7
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (done == 8'd0 && rd_ptr == '0 && wr_ptr == '0)); // R4
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
    .busy(busy), .done(done), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
    .opcode(opcode), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/spi_cmd_engine_test.sv
module spi_cmd_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int DEPTH      = 71;

    logic       clk, rst_n, wr_en, spi_miso;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
    logic       spi_sclk, spi_cs_n, spi_mosi;

    spi_cmd_engine #(.HALF_DIV(HALF), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    int n_cmp = 0, n_bad = 0;
    bit reported = 0;

    // behavioural reference state
    bit         m_act = 0;
    int         t = 0, m_n = 1, m_done_fin = 0, rise_cnt = 0;
    int         m_rdptr = 0, m_wrptr = 0;
    logic [7:0] m_op = 0, m_tx = 0, m_rx = 0;
    logic [7:0] m_fifo [DEPTH];
    logic [7:0] sl_rx [$];
    logic [7:0] sl_all [$];
    logic [7:0] exp_bytes [$];
    bit         prev_sclk = 0;

    initial begin
        clk = 0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    function automatic logic slave_bit(input int k);
        if (k >= 8 * sl_all.size()) return 1'b0;
        return sl_all[k / 8][7 - (k % 8)];
    endfunction

    task automatic cycle();
        bit pre;
        int e_done;
        bit e_sclk;
        logic [7:0] v;
        @(posedge clk);
        pre = m_act;
        if (m_act) begin
            t++;
            if (t == (16 * m_n + 1) * HALF) begin
                m_act = 0;
                m_done_fin = m_n - 1;
                for (int i = 0; i < int'(m_rx); i++)
                    if (int'(m_tx) + i < DEPTH) m_fifo[int'(m_tx) + i] = sl_rx[i];
                m_rdptr = int'(m_tx);
                m_wrptr = int'(m_rx);
            end
        end
        if (wr_en && !pre) begin
            if (wr_addr == 8'h45) m_op = wr_data;
            if (wr_addr == 8'h48) m_tx = wr_data;
            if (wr_addr == 8'h4B) m_rx = wr_data;
            if (wr_addr >= 8'h80 && int'(wr_addr) - 128 < DEPTH) m_fifo[int'(wr_addr) - 128] = wr_data;
            if (wr_addr == 8'h47 && wr_data[7]) begin
                m_act = 1; t = 0; rise_cnt = 0; m_done_fin = 0;
                m_n = 1 + int'(m_tx) + int'(m_rx);
                exp_bytes = {}; sl_all = {};
                exp_bytes.push_back(m_op); sl_all.push_back(8'h3C);
                for (int i = 0; i < int'(m_tx); i++) begin
                    exp_bytes.push_back(m_fifo[i]); sl_all.push_back(8'h96);
                end
                for (int i = 0; i < int'(m_rx); i++) begin
                    exp_bytes.push_back(8'hFF); sl_all.push_back(sl_rx[i]);
                end
            end
        end
        @(negedge clk);
        wr_en = 0;
        e_sclk = m_act && t >= HALF && t < 16 * m_n * HALF && (((t - HALF) / HALF) % 2 == 0);
        e_done = m_done_fin;
        if (m_act) begin
            e_done = 0;
            for (int j = 1; j < m_n; j++) if (t >= (16 * j + 16) * HALF) e_done++;
        end
        chk("R6 cs_n", int'(spi_cs_n), int'(!m_act));
        chk(m_act ? "R6 sclk" : "R11 sclk parked", int'(spi_sclk), int'(e_sclk));
        peek(8'h4F, v);
        chk("R4 busy bit", int'(v[7]), int'(m_act));
        peek(8'h4C, v);
        chk("R8 done count", int'(v), e_done);
        if (spi_sclk && !prev_sclk) begin
            if (rise_cnt < 8 * exp_bytes.size())
                chk("R5 mosi bit", int'(spi_mosi), int'(exp_bytes[rise_cnt / 8][7 - (rise_cnt % 8)]));
            rise_cnt++;
        end
        prev_sclk = spi_sclk;
        spi_miso = slave_bit(rise_cnt);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_addr = a; wr_data = d; wr_en = 1;
        cycle();
    endtask

    task automatic run_txn(input logic [7:0] op, input int tx, input int rx,
                           input int seed, input bit meddle);
        int len = 0;
        logic [7:0] v;
        sl_rx = {};
        for (int i = 0; i < rx; i++) sl_rx.push_back(8'(seed * 29 + i * 53 + 7));
        for (int i = 0; i < tx; i++) wr(8'(128 + i), 8'(seed * 11 + i * 37 + 1));
        wr(8'h48, 8'(tx));
        wr(8'h4B, 8'(rx));
        wr(8'h45, op);
        wr(8'h47, 8'h80);
        len = 1;
        if (meddle) begin
            repeat (5) begin cycle(); len++; end
            wr(8'h45, ~op);         len++;
            wr(8'h48, 8'h01);       len++;
            wr(8'h80, 8'h5A);       len++;
            wr(8'h47, 8'h80);       len++;
        end
        while (m_act && len < 5000) begin cycle(); len++; end
        chk("R6 busy length", len, (16 * (1 + tx + rx) + 1) * HALF + 1);
        if (tx == 0 && rx == 0) chk("R9 opcode-only length", len, 17 * HALF + 1);
        for (int i = 0; i < DEPTH; i++) begin
            peek(8'(128 + i), v);
            chk(i >= tx && i < tx + rx ? "R7 reply slot" : "R7 other slot", int'(v), int'(m_fifo[i]));
        end
        peek(8'h4D, v); chk("R4 write pointer", int'(v), m_wrptr);
        peek(8'h4E, v); chk("R4 read pointer", int'(v), m_rdptr);
        peek(8'h45, v); chk(meddle ? "R10 opcode kept" : "R2 opcode", int'(v), int'(m_op));
        peek(8'h48, v); chk(meddle ? "R10 tx count kept" : "R2 tx count", int'(v), int'(m_tx));
        peek(8'h4B, v); chk("R2 rx count", int'(v), int'(m_rx));
    endtask

    initial begin
        logic [7:0] v;
        for (int i = 0; i < DEPTH; i++) m_fifo[i] = 8'h00;
        rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 8'h4F; spi_miso = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 cs_n in reset", int'(spi_cs_n), 1);
        rst_n = 1;
        cycle();
        chk("R1 sclk", int'(spi_sclk), 0);
        for (int a = 8'h4C; a <= 8'h4F; a++) begin
            peek(8'(a), v);
            chk("R1 status byte", int'(v), 0);
        end
        // R2 register window readback
        wr(8'h45, 8'h9F); wr(8'h48, 8'h03); wr(8'h4B, 8'h04);
        wr(8'h80, 8'hA1); wr(8'hC6, 8'h7E);
        peek(8'h45, v); chk("R2 opcode readback", int'(v), 8'h9F);
        peek(8'h48, v); chk("R2 tx readback", int'(v), 8'h03);
        peek(8'h4B, v); chk("R2 rx readback", int'(v), 8'h04);
        peek(8'h80, v); chk("R2 first slot", int'(v), 8'hA1);
        peek(8'hC6, v); chk("R2 last slot", int'(v), 8'h7E);
        // R3 go write with bit 7 clear does nothing
        wr(8'h47, 8'h7F);
        repeat (4) cycle();
        chk("R3 no start", int'(spi_cs_n), 1);
        run_txn(8'h0B, 3, 4, 1, 0);
        run_txn(8'hD8, 2, 3, 2, 1);   // R10 writes during busy
        run_txn(8'h06, 0, 0, 3, 0);   // R9
        run_txn(8'h02, 5, 0, 4, 0);
        run_txn(8'h9F, 0, 6, 5, 0);
        run_txn(8'hEB, 30, 41, 6, 0); // R7 fills the whole buffer
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
        $finish;
    end
endmodule